// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year covering 2000 to 2099. A single-cycle enable, pulsed at 32768 Hz, drives a sub-second prescaler. When the prescaler wraps, the time advances by one second. The carry chain runs through every field and knows the month lengths and leap years.

Software uses a byte-wide register port with a combinational read. The time fields sit at word-spaced offsets: 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month and 0x14 year. Offset 0x40 is the control byte. Offset 0x44 is the status byte. A busy bit in the status byte covers the last prescaler tick before each update, so software can see when reading or loading the time is unsafe. Sticky event bits record second, minute, hour and day boundaries.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the time fields read seconds 00, minutes 00, hours 00, day 01, month 01 and year 00 at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. Control (0x40) and status (0x44) both read 0x00.
- R2: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap increments the next field in the same update.
- R3: Control bit 0 is the run bit. While it is 0, tick pulses leave every time field unchanged. Status bit 1 reads back the run bit.
- R4: The day wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. Otherwise the day simply increments.
- R5: In month 02 the day wraps after 29 when the year is divisible by 4, and after 28 otherwise.
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: With TICKS_PER_SEC ticks per second, status bit 0 (busy) is 1 exactly when running with the prescaler at its last count. The one-second update happens on the tick taken while busy.
- R8: Status bits 2, 3, 4 and 5 are sticky. They set on every second update, on a minute change, on an hour change and on a day change respectively.
- R9: Writing a 1 to status bits 2 to 5 clears the matching event bits. Zeros written there have no effect.
- R10: A write to a time field takes effect at the next clock edge and clears the prescaler. If it coincides with an update tick, the written value wins, no advance happens and no event is raised.
- R11: Control bit 3 (12/24-hour mode) always reads 0, whatever is written to it, so hours stay in 24-hour form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 32768 Hz single-cycle enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
Two things can land in the same clock: a software load of the seconds byte and the one-second update it would otherwise race. The bench advances the prescaler to its last count, checks that busy reads 1, and then drives the update tick and a seconds write in the same cycle. It then checks three results: the written value is present, the second event stays clear, and a full second of further ticks is needed before the next advance.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [ADDR_W-1:0] A_SEC = 'h00, A_MIN = 'h04, A_HR = 'h08,
                                A_DAY = 'h0C, A_MON = 'h10, A_YR = 'h14,
                                A_CTL = 'h40, A_STA = 'h44;

  logic [7:0]    sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic [PW-1:0] pre_q;
  logic          run_q;
  logic [3:0]    ev_q;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic tw, busy, upd, leap, c_s, c_m, c_h, c_d, c_mo;
  logic [7:0] dim;
  logic [3:0] ev_set, ev_clr;

  assign tw   = wr_en && (addr == A_SEC || addr == A_MIN || addr == A_HR ||
                          addr == A_DAY || addr == A_MON || addr == A_YR);
  assign busy = run_q && (pre_q == LAST);
  assign upd  = tick && busy && !tw;

  assign leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                        : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);
  assign dim  = (mon_q == 8'h02) ? (leap ? 8'h29 : 8'h28) :
                (mon_q == 8'h04 || mon_q == 8'h06 || mon_q == 8'h09 || mon_q == 8'h11)
                  ? 8'h30 : 8'h31;

  assign c_s  = sec_q == 8'h59;
  assign c_m  = c_s && min_q == 8'h59;
  assign c_h  = c_m && hr_q == 8'h23;
  assign c_d  = c_h && day_q == dim;
  assign c_mo = c_d && mon_q == 8'h12;

  assign ev_set = {upd && c_h, upd && c_m, upd && c_s, upd};
  assign ev_clr = (wr_en && addr == A_STA) ? wdata[5:2] : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
      pre_q <= '0;
      run_q <= 1'b0;
      ev_q  <= 4'd0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set;
      if (wr_en && addr == A_CTL) run_q <= wdata[0];
      if (tw) begin
        pre_q <= '0;
        case (addr)
          A_SEC:   sec_q <= wdata;
          A_MIN:   min_q <= wdata;
          A_HR:    hr_q  <= wdata;
          A_DAY:   day_q <= wdata;
          A_MON:   mon_q <= wdata;
          default: yr_q  <= wdata;
        endcase
      end else if (tick && run_q) begin
        pre_q <= busy ? '0 : pre_q + 1'b1;
        if (upd) begin
          sec_q <= c_s ? 8'h00 : binc(sec_q);
          if (c_s)  min_q <= c_m ? 8'h00 : binc(min_q);
          if (c_m)  hr_q  <= c_h ? 8'h00 : binc(hr_q);
          if (c_h)  day_q <= c_d ? 8'h01 : binc(day_q);
          if (c_d)  mon_q <= c_mo ? 8'h01 : binc(mon_q);
          if (c_mo) yr_q  <= (yr_q == 8'h99) ? 8'h00 : binc(yr_q);
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = sec_q;
      A_MIN:   rdata = min_q;
      A_HR:    rdata = hr_q;
      A_DAY:   rdata = day_q;
      A_MON:   rdata = mon_q;
      A_YR:    rdata = yr_q;
      A_CTL:   rdata = {7'd0, run_q};
      A_STA:   rdata = {2'b00, ev_q, run_q, busy};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
  parameter int PW     = 15,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              run,
  input logic              busy,
  input logic [PW-1:0]     pre,
  input logic [7:0]        sec,
  input logic [7:0]        mn,
  input logic              ev_s
);
  logic tw;
  assign tw = wr_en && (addr == 'h00 || addr == 'h04 || addr == 'h08 ||
                        addr == 'h0C || addr == 'h10 || addr == 'h14);

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !tw) |=> ($stable(sec) && $stable(mn)));

  assert_update_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !tw) |=> (sec != $past(sec)));

  assert_no_midsecond_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tw && !(busy && tick)) |=> $stable(sec));

  assert_sec_event_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_s) |-> $past(busy && tick && !tw));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 'h00) |=> (sec == $past(wdata) && pre == '0));
endmodule

bind bcd_calendar bcd_calendar_chk #(.PW(PW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .run(run_q), .busy(busy), .pre(pre_q), .sec(sec_q),
  .mn(min_q), .ev_s(ev_q[0])
);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  localparam int TPS = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  int n_vec = 0, n_bad = 0;
  int bs, bm, bh, bd, bmo, by;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) i_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    bs++;
    if (bs == 60) begin bs = 0; bm++; end
    if (bm == 60) begin bm = 0; bh++; end
    if (bh == 24) begin bh = 0; bd++; end
    if (bd > dim(bmo, by)) begin bd = 1; bmo++; end
    if (bmo > 12) begin bmo = 1; by++; end
    if (by > 99) by = 0;
  endtask

  task automatic cyc(input logic t, input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    tick = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_time(input string tag);
    chk_reg({tag, " sec"},  8'h00, bcd(bs));
    chk_reg({tag, " min"},  8'h04, bcd(bm));
    chk_reg({tag, " hr"},   8'h08, bcd(bh));
    chk_reg({tag, " day"},  8'h0C, bcd(bd));
    chk_reg({tag, " mon"},  8'h10, bcd(bmo));
    chk_reg({tag, " yr"},   8'h14, bcd(by));
  endtask

  task automatic load(input int s, input int m, input int h, input int d, input int mo, input int y);
    cyc(0, 1, 8'h00, bcd(s)); cyc(0, 1, 8'h04, bcd(m)); cyc(0, 1, 8'h08, bcd(h));
    cyc(0, 1, 8'h0C, bcd(d)); cyc(0, 1, 8'h10, bcd(mo)); cyc(0, 1, 8'h14, bcd(y));
    bs = s; bm = m; bh = h; bd = d; bmo = mo; by = y;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h00, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int yl[7];
    yl = '{0, 1, 2, 3, 4, 96, 99};
    bs = 0; bm = 0; bh = 0; bd = 1; bmo = 1; by = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset values
    chk_time("R1 reset");
    chk_reg("R1 ctrl", 8'h40, 8'h00);
    chk_reg("R1 status", 8'h44, 8'h00);
    // R3: stopped clock ignores ticks
    ticks(3 * TPS);
    chk_time("R3 stopped");
    chk_reg("R3 status stopped", 8'h44, 8'h00);
    // R11: mode bit reads 0; R3: run mirrored
    cyc(0, 1, 8'h40, 8'h09);
    chk_reg("R11 ctrl mode bit", 8'h40, 8'h01);
    chk_reg("R3 running", 8'h44, 8'h02);
    // R7: busy on last tick count
    ticks(TPS - 2);
    chk_reg("R7 not yet busy", 8'h44, 8'h02);
    ticks(1);
    chk_reg("R7 busy", 8'h44, 8'h03);
    chk_reg("R7 no advance yet", 8'h00, 8'h00);
    ticks(1);
    model_adv();
    chk_time("R7 advanced");
    chk_reg("R8 sec event", 8'h44, 8'h06);
    // R9: clear with ones, zeros ignored
    cyc(0, 1, 8'h44, 8'h00);
    chk_reg("R9 zero write keeps", 8'h44, 8'h06);
    cyc(0, 1, 8'h44, 8'h04);
    chk_reg("R9 cleared", 8'h44, 8'h02);
    // R2: second-by-second sweep across minute and hour boundaries
    load(0, 58, 22, 15, 6, 23);
    for (int k = 0; k < 130; k++) begin
      ticks(TPS);
      model_adv();
      chk_time("R2 sweep");
    end
    chk_reg("R8 minute and hour events", 8'h44, 8'h1E);
    cyc(0, 1, 8'h44, 8'h3C);
    load(59, 59, 23, 31, 12, 45);
    ticks(TPS); model_adv();
    chk_time("R2 R6 full carry");
    // R4 R5 R6: month-end sweep over years and months
    foreach (yl[j]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        cyc(0, 1, 8'h44, 8'h3C);
        load(59, 59, 23, dim(mo, yl[j]) - 1, mo, yl[j]);
        ticks(TPS); model_adv();
        chk_time("R4 R5 day before end");
        chk_reg("R8 day event", 8'h44, 8'h3E);
        load(59, 59, 23, dim(mo, yl[j]), mo, yl[j]);
        ticks(TPS); model_adv();
        chk_time("R4 R5 R6 month end");
      end
    end
    // R10: write clears prescaler
    cyc(0, 1, 8'h44, 8'h3C);
    ticks(2);
    cyc(0, 1, 8'h00, 8'h10);
    ticks(TPS - 1);
    chk_reg("R10 restarted second", 8'h00, 8'h10);
    chk_reg("R10 busy after reload", 8'h44, 8'h03);
    ticks(1);
    chk_reg("R10 advance after full second", 8'h00, 8'h11);
    // R10: write colliding with update tick
    cyc(0, 1, 8'h44, 8'h3C);
    ticks(TPS - 1);
    chk_reg("R10 busy before collision", 8'h44, 8'h03);
    cyc(1, 1, 8'h00, 8'h30);
    chk_reg("R10 write wins", 8'h00, 8'h30);
    chk_reg("R10 no event on collision", 8'h44, 8'h02);
    ticks(TPS - 1);
    chk_reg("R10 still held", 8'h00, 8'h30);
    ticks(1);
    chk_reg("R10 next advance", 8'h00, 8'h31);
    // R3: stop mid-second freezes
    ticks(2);
    cyc(0, 1, 8'h40, 8'h00);
    ticks(4 * TPS);
    chk_reg("R3 frozen", 8'h00, 8'h31);
    chk_reg("R3 status run low", 8'h44, 8'h04);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule